// File: doc/BRIEF.md
# Bitmap Row Pixel Search Engine

This block is a small command unit that looks along one row of an 8-bit bitmap for a pixel that satisfies a colour test. Software first loads the start coordinates, the reference colour, the image width and the search mode through a small register port, in any order it likes. It then writes the search command code. The engine takes a copy of the settings, clips the start point to the image width, and reads one pixel per clock from an external synchronous video memory. It stops at the first pixel that passes the test or at the edge of the row.

At the end the engine records whether a pixel matched and stores a border x coordinate. This is the matching x, or the row edge when no pixel matched. It also raises a sticky completion interrupt. A busy bit in the status register covers the whole run.

Top module: `pixel_search_top`

## Requirements
- R1: After reset, the status register (address 6: bit0 busy, bit1 match, bit2 interrupt) reads 0, the border register reads 0, the irq pin is low and mem_re is low.
- R2: The parameter registers read back what was last written, whatever the write order. They are: address 0 start x, address 1 start y, address 2 reference colour in bits [7:0], address 3 width code in bits [1:0], address 4 mode. A search starts only on a write to address 5 with wdata[3:0] = 0xC. Any other value written there leaves busy low and issues no memory read.
- R3: The busy bit is set by the clock edge that takes the start write. It stays set for exactly n+1 cycles, where n is the number of pixels compared. It falls on the edge where the result is recorded.
- R4: The interrupt bit (status bit2, mirrored on the irq pin) is set when a search completes. It stays set until the host writes status with bit2 = 1. A status write with bit2 = 0 leaves it set.
- R5: The match bit is 1 after a search that found a passing pixel and 0 after one that did not.
- R6: Every completed search writes the border register (address 7). It holds the matching x, or the row edge on no match: width-1 when scanning upward, 0 when scanning downward.
- R7: Width code c selects an image width W = 256 << c (256, 512, 1024, 2048). The start x and start y are ANDed with W-1 before use.
- R8: Mode bit0 picks the scan direction: 0 means increasing x, 1 means decreasing x. The scan never passes the row edge.
- R9: Mode bit1 picks the colour test: 0 means a pixel matches when it equals the reference colour, 1 means it matches when it differs.
- R10: A read is issued on at most one pixel per cycle at address (y << (8+c)) | x, with y the masked start y. Its data is expected on mem_rdata in the cycle after mem_re.
- R11: While busy, a write of the start code is ignored. Writes to the parameter registers do not change the running search.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 11 | Register write data |
| reg_rdata | output | 11 | Register read data (combinational on reg_addr) |
| irq | output | 1 | Search-complete interrupt flag |
| mem_re | output | 1 | Video memory read enable |
| mem_addr | output | 22 | Video memory pixel address |
| mem_rdata | input | 8 | Video memory read data, one cycle after mem_re |

## Verification
A wrong scan position or row register shows up at the ports in two ways. The recorded border x is wrong, and the busy interval has the wrong length. Both are visible on the completion edge, so the first wrong pixel compared already changes the result. A masking or shift fault puts mem_addr outside the expected row on the first read after the start edge. A broken flag update shows in the status register one cycle after completion. A restart while busy shows as a shifted border and a longer busy interval.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

  typedef enum logic [2:0] {
    RA_SX     = 3'd0,
    RA_SY     = 3'd1,
    RA_REF    = 3'd2,
    RA_WID    = 3'd3,
    RA_MODE   = 3'd4,
    RA_OP     = 3'd5,
    RA_STAT   = 3'd6,
    RA_BORDER = 3'd7
  } ra_e;

  localparam logic [3:0] OP_SEARCH = 4'hC;

  localparam int SB_BUSY  = 0;
  localparam int SB_MATCH = 1;
  localparam int SB_IRQ   = 2;

  localparam int MB_DIR  = 0;
  localparam int MB_DIFF = 1;

  typedef enum logic [1:0] {
    EN_IDLE  = 2'd0,
    EN_RUN   = 2'd1,
    EN_DRAIN = 2'd2
  } eng_e;

endpackage

// File: rtl/pxs_regs.sv
module pxs_regs
  import pxs_pkg::*;
#(
  parameter int X_W    = 11,
  parameter int PIX_W  = 8,
  parameter int WSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [X_W-1:0]    wdata,
  output logic [X_W-1:0]    rdata,
  input  logic              busy,
  input  logic              done,
  input  logic              done_match,
  input  logic [X_W-1:0]    done_x,
  output logic [X_W-1:0]    sx,
  output logic [X_W-1:0]    sy,
  output logic [PIX_W-1:0]  ref_pix,
  output logic [WSEL_W-1:0] wsel,
  output logic              dir,
  output logic              diff,
  output logic              start,
  output logic              irq
);

  logic [X_W-1:0]    sx_q, sx_d, sy_q, sy_d, border_q, border_d;
  logic [PIX_W-1:0]  ref_q, ref_d;
  logic [WSEL_W-1:0] wsel_q, wsel_d;
  logic              dir_q, dir_d, diff_q, diff_d;
  logic              match_q, match_d, irq_q, irq_d;
  logic              irq_clr;

  always_comb begin
    sx_d     = sx_q;
    sy_d     = sy_q;
    ref_d    = ref_q;
    wsel_d   = wsel_q;
    dir_d    = dir_q;
    diff_d   = diff_q;
    if (we) begin
      unique case (addr)
        RA_SX:   sx_d   = wdata;
        RA_SY:   sy_d   = wdata;
        RA_REF:  ref_d  = wdata[PIX_W-1:0];
        RA_WID:  wsel_d = wdata[WSEL_W-1:0];
        RA_MODE: begin
          dir_d  = wdata[MB_DIR];
          diff_d = wdata[MB_DIFF];
        end
        default: ;
      endcase
    end
    start    = we && (addr == RA_OP) && (wdata[3:0] == OP_SEARCH) && !busy;
    irq_clr  = we && (addr == RA_STAT) && wdata[SB_IRQ];
    match_d  = start ? 1'b0 : (done ? done_match : match_q);
    border_d = done ? done_x : border_q;
    if (done)         irq_d = 1'b1;
    else if (irq_clr) irq_d = 1'b0;
    else              irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sx_q     <= '0;
      sy_q     <= '0;
      ref_q    <= '0;
      wsel_q   <= '0;
      dir_q    <= 1'b0;
      diff_q   <= 1'b0;
      match_q  <= 1'b0;
      irq_q    <= 1'b0;
      border_q <= '0;
    end else begin
      sx_q     <= sx_d;
      sy_q     <= sy_d;
      ref_q    <= ref_d;
      wsel_q   <= wsel_d;
      dir_q    <= dir_d;
      diff_q   <= diff_d;
      match_q  <= match_d;
      irq_q    <= irq_d;
      border_q <= border_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      RA_SX:     rdata = sx_q;
      RA_SY:     rdata = sy_q;
      RA_REF:    rdata = X_W'(ref_q);
      RA_WID:    rdata = X_W'(wsel_q);
      RA_MODE:   rdata = X_W'({diff_q, dir_q});
      RA_STAT:   rdata = X_W'({irq_q, match_q, busy});
      RA_BORDER: rdata = border_q;
      default:   rdata = '0;
    endcase
  end

  assign sx      = sx_q;
  assign sy      = sy_q;
  assign ref_pix = ref_q;
  assign wsel    = wsel_q;
  assign dir     = dir_q;
  assign diff    = diff_q;
  assign irq     = irq_q;

  // R4: completion sets the flag, only a write of 1 clears it
  a_r4_irq_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> irq_q);
  a_r4_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !irq_clr |=> irq_q);
  // R5: match flag follows the result of the finished search
  a_r5_match_latch: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> match_q == $past(done_match));
  // R6: border written on every completion
  a_r6_border_latch: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> border_q == $past(done_x));
  // R11: a start write during a run does not disturb it
  a_r11_busy_op_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done && we && (addr == RA_OP) |=> busy);

endmodule

// File: rtl/pxs_engine.sv
module pxs_engine
  import pxs_pkg::*;
#(
  parameter int X_W     = 11,
  parameter int PIX_W   = 8,
  parameter int WSEL_W  = 2,
  parameter int MIN_LOG = 8,
  localparam int AW     = 2 * X_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [X_W-1:0]    sx,
  input  logic [X_W-1:0]    sy,
  input  logic [PIX_W-1:0]  ref_pix,
  input  logic [WSEL_W-1:0] wsel,
  input  logic              dir,
  input  logic              diff,
  input  logic [PIX_W-1:0]  mem_rdata,
  output logic              busy,
  output logic              mem_re,
  output logic [AW-1:0]     mem_addr,
  output logic              done,
  output logic              done_match,
  output logic [X_W-1:0]    done_x
);

  function automatic logic [X_W-1:0] width_mask(input logic [WSEL_W-1:0] w);
    logic [X_W:0] span;
    span = (X_W+1)'(1) << (MIN_LOG + int'(w));
    return X_W'(span - 1'b1);
  endfunction

  eng_e              state_q, state_d;
  logic [X_W-1:0]    x_q, x_d, y_q, y_d, rdx_q, rdx_d;
  logic [WSEL_W-1:0] wsel_q, wsel_d;
  logic              dir_q, dir_d, diff_q, diff_d, rdv_q, rdv_d;
  logic [PIX_W-1:0]  ref_q, ref_d;
  logic [X_W-1:0]    mask_in, mask_q, edge_x;
  logic              hit;

  assign mask_in = width_mask(wsel);
  assign mask_q  = width_mask(wsel_q);
  assign edge_x  = dir_q ? '0 : mask_q;
  assign hit     = diff_q ? (mem_rdata != ref_q) : (mem_rdata == ref_q);

  always_comb begin
    state_d    = state_q;
    x_d        = x_q;
    y_d        = y_q;
    wsel_d     = wsel_q;
    dir_d      = dir_q;
    diff_d     = diff_q;
    ref_d      = ref_q;
    rdv_d      = 1'b0;
    rdx_d      = rdx_q;
    mem_re     = 1'b0;
    done       = 1'b0;
    done_match = 1'b0;
    unique case (state_q)
      EN_IDLE: begin
        if (start) begin
          state_d = EN_RUN;
          x_d     = sx & mask_in;
          y_d     = sy & mask_in;
          wsel_d  = wsel;
          dir_d   = dir;
          diff_d  = diff;
          ref_d   = ref_pix;
        end
      end
      EN_RUN: begin
        mem_re = 1'b1;
        rdv_d  = 1'b1;
        rdx_d  = x_q;
        if (rdv_q && hit) begin
          done       = 1'b1;
          done_match = 1'b1;
          rdv_d      = 1'b0;
          state_d    = EN_IDLE;
        end else if (x_q == edge_x) begin
          state_d = EN_DRAIN;
        end else begin
          x_d = dir_q ? x_q - 1'b1 : x_q + 1'b1;
        end
      end
      EN_DRAIN: begin
        done       = 1'b1;
        done_match = hit;
        state_d    = EN_IDLE;
      end
      default: state_d = EN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= EN_IDLE;
      x_q     <= '0;
      y_q     <= '0;
      wsel_q  <= '0;
      dir_q   <= 1'b0;
      diff_q  <= 1'b0;
      ref_q   <= '0;
      rdv_q   <= 1'b0;
      rdx_q   <= '0;
    end else begin
      state_q <= state_d;
      x_q     <= x_d;
      y_q     <= y_d;
      wsel_q  <= wsel_d;
      dir_q   <= dir_d;
      diff_q  <= diff_d;
      ref_q   <= ref_d;
      rdv_q   <= rdv_d;
      rdx_q   <= rdx_d;
    end
  end

  assign busy     = (state_q != EN_IDLE);
  assign mem_addr = (AW'(y_q) << (MIN_LOG + int'(wsel_q))) | AW'(x_q);
  assign done_x   = rdx_q;

  // R3: completion leaves the engine idle with no read pending
  a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy && !mem_re);
  // R7: every issued x lies inside the selected width
  a_r7_x_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> (x_q & ~mask_q) == '0);
  // R8: consecutive reads step by one in the chosen direction
  a_r8_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re && $past(mem_re) && !dir_q |-> x_q == $past(x_q) + 1'b1);
  a_r8_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re && $past(mem_re) && dir_q |-> x_q == $past(x_q) - 1'b1);
  // R10: the row stays fixed for the whole run
  a_r10_row_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re && $past(mem_re) |-> $stable(y_q) && $stable(wsel_q));

endmodule

// File: rtl/pixel_search_top.sv
module pixel_search_top
  import pxs_pkg::*;
#(
  parameter int X_W     = 11,
  parameter int PIX_W   = 8,
  parameter int WSEL_W  = 2,
  parameter int MIN_LOG = 8,
  localparam int AW     = 2 * X_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [X_W-1:0]   reg_wdata,
  output logic [X_W-1:0]   reg_rdata,
  output logic             irq,
  output logic             mem_re,
  output logic [AW-1:0]    mem_addr,
  input  logic [PIX_W-1:0] mem_rdata
);

  logic [1:0] rst_sync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  logic [X_W-1:0]    sx, sy, done_x;
  logic [PIX_W-1:0]  ref_pix;
  logic [WSEL_W-1:0] wsel;
  logic              dir, diff, start, busy, done, done_match;

  pxs_regs #(
    .X_W(X_W), .PIX_W(PIX_W), .WSEL_W(WSEL_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_sn),
    .we         (reg_we),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .busy       (busy),
    .done       (done),
    .done_match (done_match),
    .done_x     (done_x),
    .sx         (sx),
    .sy         (sy),
    .ref_pix    (ref_pix),
    .wsel       (wsel),
    .dir        (dir),
    .diff       (diff),
    .start      (start),
    .irq        (irq)
  );

  pxs_engine #(
    .X_W(X_W), .PIX_W(PIX_W), .WSEL_W(WSEL_W), .MIN_LOG(MIN_LOG)
  ) u_engine (
    .clk        (clk),
    .rst_n      (rst_sn),
    .start      (start),
    .sx         (sx),
    .sy         (sy),
    .ref_pix    (ref_pix),
    .wsel       (wsel),
    .dir        (dir),
    .diff       (diff),
    .mem_rdata  (mem_rdata),
    .busy       (busy),
    .mem_re     (mem_re),
    .mem_addr   (mem_addr),
    .done       (done),
    .done_match (done_match),
    .done_x     (done_x)
  );

endmodule

// File: tb/tb_pixel_search_top.sv
`timescale 1ns/1ps
module tb_pixel_search_top;
  import pxs_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [10:0] reg_wdata;
  logic [10:0] reg_rdata;
  logic        irq;
  logic        mem_re;
  logic [21:0] mem_addr;
  logic [7:0]  mem_rdata;

  always #4 clk = ~clk;

  pixel_search_top dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  logic [7:0] vmem [int];

  function automatic logic [7:0] vpix(input int a);
    if (vmem.exists(a)) return vmem[a];
    return 8'h00;
  endfunction

  always @(posedge clk) if (mem_re) mem_rdata <= vpix(int'(mem_addr));

  int tests = 0;
  int fails = 0;
  int addr_err = 0;
  int reads = 0;
  bit mon_en = 1'b0;
  int mon_shift = 8;
  int mon_y = 0;

  always @(negedge clk) begin
    if (mem_re) reads++;
    if (mon_en && mem_re && ((int'(mem_addr) >> mon_shift) != mon_y)) addr_err++;
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [10:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [10:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  typedef struct packed {
    logic [10:0] sx;
    logic [10:0] sy;
    logic [7:0]  refc;
    logic [1:0]  w;
    logic        dir;
    logic        diff;
    logic        em;
    logic [10:0] eb;
    logic [7:0]  ecyc;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{11'd10,   11'd3,     8'h5A, 2'd0, 1'b0, 1'b0, 1'b1, 11'd40,   8'd32},
    '{11'd100,  11'd3,     8'h5A, 2'd0, 1'b1, 1'b0, 1'b1, 11'd40,   8'd62},
    '{11'd200,  11'd3,     8'h5A, 2'd0, 1'b0, 1'b0, 1'b1, 11'd200,  8'd2},
    '{11'd201,  11'd3,     8'h5A, 2'd0, 1'b0, 1'b0, 1'b0, 11'd255,  8'd56},
    '{11'd39,   11'd3,     8'h5A, 2'd0, 1'b1, 1'b0, 1'b0, 11'd0,    8'd41},
    '{11'd1320, 11'h205,   8'h33, 2'd1, 1'b0, 1'b0, 1'b1, 11'd300,  8'd6},
    '{11'd266,  11'd3,     8'h00, 2'd0, 1'b0, 1'b1, 1'b1, 11'd40,   8'd32},
    '{11'd2000, 11'd1,     8'h77, 2'd3, 1'b0, 1'b0, 1'b1, 11'd2040, 8'd42},
    '{11'd5,    11'd9,     8'hEE, 2'd0, 1'b1, 1'b0, 1'b0, 11'd0,    8'd7},
    '{11'd40,   11'd3,     8'h00, 2'd0, 1'b1, 1'b1, 1'b1, 11'd40,   8'd2},
    '{11'd39,   11'd3,     8'h00, 2'd0, 1'b1, 1'b1, 1'b0, 11'd0,    8'd41},
    '{11'd1023, 11'd2,     8'h00, 2'd2, 1'b0, 1'b0, 1'b1, 11'd1023, 8'd2}
  };

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [10:0] d;
    int cnt, a0, e0;
    vmem[(3 << 8) | 40]    = 8'h5A;
    vmem[(3 << 8) | 200]   = 8'h5A;
    vmem[(5 << 9) | 300]   = 8'h33;
    vmem[(1 << 11) | 2040] = 8'h77;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    rd(RA_STAT, d);   chk("R1 status after reset", int'(d), 0);
    rd(RA_BORDER, d); chk("R1 border after reset", int'(d), 0);
    chk("R1 irq pin after reset", int'(irq), 0);
    chk("R1 mem_re after reset", int'(mem_re), 0);
    @(negedge clk);

    // R2: any write order, readback; a wrong opcode value does nothing
    wr(RA_MODE, 11'd3); wr(RA_SY, 11'd77); wr(RA_REF, 11'h0A5);
    wr(RA_SX, 11'd1234); wr(RA_WID, 11'd2);
    rd(RA_SX, d);   chk("R2 sx readback", int'(d), 1234);
    rd(RA_SY, d);   chk("R2 sy readback", int'(d), 77);
    rd(RA_REF, d);  chk("R2 ref readback", int'(d), 'hA5);
    rd(RA_WID, d);  chk("R2 width readback", int'(d), 2);
    rd(RA_MODE, d); chk("R2 mode readback", int'(d), 3);
    @(negedge clk);
    a0 = reads;
    wr(RA_OP, 11'h003);
    rd(RA_STAT, d); chk("R2 bad opcode leaves busy low", int'(d[0]), 0);
    @(negedge clk);
    chk("R2 bad opcode issues no read", reads - a0, 0);
    rd(RA_STAT, d); chk("R2 bad opcode no irq", int'(d[2]), 0);
    @(negedge clk);

    // table walk: R3 R5 R6 R7 R8 R9 R10 R4
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      wr(RA_STAT, 11'h004);
      wr(RA_REF, 11'(v.refc));
      wr(RA_MODE, 11'({v.diff, v.dir}));
      wr(RA_WID, 11'(v.w));
      wr(RA_SY, v.sy);
      wr(RA_SX, v.sx);
      mon_shift = 8 + int'(v.w);
      mon_y = int'(v.sy) & ((256 << v.w) - 1);
      e0 = addr_err;
      mon_en = 1'b1;
      wr(RA_OP, 11'h00C);
      cnt = 0;
      while (dut.reg_rdata === 11'bx) @(negedge clk);
      rd(RA_STAT, d);
      while (d[0]) begin
        cnt++;
        @(negedge clk);
        rd(RA_STAT, d);
      end
      mon_en = 1'b0;
      chk($sformatf("R3 busy cycles vec %0d", i), cnt, int'(v.ecyc));
      chk($sformatf("R5 R9 match bit vec %0d", i), int'(d[1]), int'(v.em));
      chk($sformatf("R4 irq bit vec %0d", i), int'(d[2]), 1);
      chk($sformatf("R4 irq pin vec %0d", i), int'(irq), 1);
      rd(RA_BORDER, d);
      chk($sformatf("R6 R7 R8 border vec %0d", i), int'(d), int'(v.eb));
      chk($sformatf("R10 row address vec %0d", i), addr_err - e0, 0);
      @(negedge clk);
    end

    // R4: writing 0 to the flag keeps it, writing 1 clears it
    wr(RA_STAT, 11'h000);
    rd(RA_STAT, d); chk("R4 write 0 keeps irq", int'(d[2]), 1);
    @(negedge clk);
    wr(RA_STAT, 11'h004);
    rd(RA_STAT, d); chk("R4 write 1 clears irq", int'(d[2]), 0);
    chk("R4 irq pin cleared", int'(irq), 0);
    @(negedge clk);

    // R11: restart and parameter change during a run are ignored
    wr(RA_REF, 11'h05A); wr(RA_MODE, 11'd0); wr(RA_WID, 11'd0);
    wr(RA_SY, 11'd3); wr(RA_SX, 11'd10);
    wr(RA_OP, 11'h00C);
    cnt = 1;
    wr(RA_SX, 11'd200);
    cnt++;
    wr(RA_OP, 11'h00C);
    rd(RA_STAT, d);
    while (d[0]) begin
      cnt++;
      @(negedge clk);
      rd(RA_STAT, d);
    end
    chk("R11 busy cycles unchanged by restart", cnt, 32);
    chk("R11 match unchanged", int'(d[1]), 1);
    rd(RA_BORDER, d);
    chk("R11 border from original start", int'(d), 40);
    @(negedge clk);

    summary();
    $finish;
  end

endmodule